// File: doc/BRIEF.md
# Special-Register Access Unit

This unit decodes move-to and move-from special-register requests for a 32-bit RISC core. A request carries a 16-bit register address made of a 5-bit group and an 11-bit number inside that group. The unit stores an exception vector base register and a power-control register. It returns fixed identity and configuration words. It also exposes a bank of shadow general-purpose register sets through a linear address window.

The pipeline asserts a write or read strobe with the address, the write data and the PC of the instruction being executed. Read data comes back from a register one cycle later. Set 0 of the shadow bank is the live register file, and the core reads it through its own port. A power-control write that turns on doze or sleep stops the core. The unit raises a halt request and reports a next PC that skips the instruction. The halt request stays up until the wake input is pulsed.

Top module: `sreg_unit`

## Requirements
- R1: An address is (group << 11) + number. The vector base register sits at group 0, number 11 (0x000B). It holds all 32 bits, reads back what was last written, and resets to 0.
- R2: A read of group 0, number 128 (core index, 0x0080) returns 0. A read of group 0, number 129 (core count, 0x0081) returns 1.
- R3: A read of group 0, number 2 (0x0002) returns the configuration word. Bit 12 is 1 (vector base register present). Bits 3:0 hold the number of shadow sets minus one. All other bits are 0, which gives 0x0000100F for 16 sets.
- R4: Addresses 0x0400 + k, for 0 <= k < 512, reach shadow set k/32, register k%32. Each entry is read and written with its full 32 bits, independently of every other entry.
- R5: The live port returns, in the same cycle, shadow set 0 register gpr_raddr. That is the entry written through window offset k = gpr_raddr, and no entry of another set.
- R6: The power-control register sits at group 8, number 0 (0x4000). It keeps write-data bits 7:0 and resets to 0. Bits 3:0 are the slowdown factor, bit 4 enables doze, bit 5 enables sleep, bit 6 enables clock gating and bit 7 enables suspend. Bits 31:8 read as 0.
- R7: In the cycle of a power-control write with bit 4 or bit 5 set, next_pc equals cur_pc + 4. In every other cycle next_pc equals cur_pc. halt_req is high from the next cycle on.
- R8: halt_req stays high until wake is pulsed. Wake clears halt_req one cycle later and clears bits 4 and 5 of the power-control register. If a halting write arrives in the same cycle as wake, the write wins and halt_req stays high.
- R9: A read of any other address returns 0. A write to any other address changes nothing: this includes 0x0600, just past the window, and 0x4001.
- R10: rd_data presents the value one cycle after the read strobe and holds it until the next read. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 16 | Special-register address |
| req_wdata | input | 32 | Write data |
| req_we | input | 1 | Write strobe |
| req_re | input | 1 | Read strobe |
| cur_pc | input | 32 | PC of the current instruction |
| wake | input | 1 | Wake pulse, ends a halt |
| gpr_raddr | input | 5 | Live register file read index (set 0) |
| gpr_rdata | output | 32 | Live register file read data |
| rd_data | output | 32 | Registered read data |
| halt_req | output | 1 | Halt request to the core |
| next_pc | output | 32 | PC at which execution resumes |

## Verification
next_pc and gpr_rdata are combinational, so the bench checks them one time unit after driving the inputs, in that same cycle. Read data and halt_req change one clock edge after their cause, so they are sampled at the falling edge that follows that edge. The read driver pushes each expected word into a queue when it raises the strobe. The monitor waits for the edge that captures the strobe, then compares at the next falling edge, so back-to-back reads stay aligned. The wake and halting-write cases are checked at the first falling edge after the strobe, and again after several idle cycles to show the state is held.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int GRP_SHIFT  = 11;
  localparam int NUM_CFG    = 2;
  localparam int NUM_VBASE  = 11;
  localparam int NUM_CID    = 128;
  localparam int NUM_NCORE  = 129;
  localparam int NUM_WIN    = 1024;
  localparam int GRP_PWR    = 8;
  localparam int PWR_W      = 8;
  localparam int DOZE_BIT   = 4;
  localparam int SLEEP_BIT  = 5;
  localparam int CFG_VB_BIT = 12;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_VBASE,
    RG_CFG,
    RG_CID,
    RG_NCORE,
    RG_PWR,
    RG_SHD
  } sreg_region_e;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSETS  = 16,
  parameter int NREGS  = 32
) (
  input  logic [ADDR_W-1:0]                       addr,
  output sreg_region_e                            region,
  output logic [$clog2(NSETS)+$clog2(NREGS)-1:0]  shd_idx
);
  localparam int OFF_W    = $clog2(NSETS) + $clog2(NREGS);
  localparam int WIN_SIZE = NSETS * NREGS;
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(NUM_CFG);
  localparam logic [ADDR_W-1:0] A_VBASE = ADDR_W'(NUM_VBASE);
  localparam logic [ADDR_W-1:0] A_CID   = ADDR_W'(NUM_CID);
  localparam logic [ADDR_W-1:0] A_NCORE = ADDR_W'(NUM_NCORE);
  localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(GRP_PWR << GRP_SHIFT);
  localparam logic [ADDR_W-1:0] A_WLO   = ADDR_W'(NUM_WIN);
  localparam logic [ADDR_W-1:0] A_WHI   = ADDR_W'(NUM_WIN + WIN_SIZE);

  logic [ADDR_W-1:0] off_full;

  always_comb begin
    off_full = addr - A_WLO;
    shd_idx  = off_full[OFF_W-1:0];
    region   = RG_NONE;
    if (addr == A_CFG)        region = RG_CFG;
    else if (addr == A_VBASE) region = RG_VBASE;
    else if (addr == A_CID)   region = RG_CID;
    else if (addr == A_NCORE) region = RG_NCORE;
    else if (addr == A_PWR)   region = RG_PWR;
    else if (addr >= A_WLO && addr < A_WHI) region = RG_SHD;
  end
endmodule

// File: rtl/sreg_shadow_bank.sv
module sreg_shadow_bank #(
  parameter int DATA_W = 32,
  parameter int NSETS  = 16,
  parameter int NREGS  = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     we,
  input  logic                                     re,
  input  logic [$clog2(NSETS)+$clog2(NREGS)-1:0]   idx,
  input  logic [DATA_W-1:0]                        wdata,
  output logic [DATA_W-1:0]                        rdata,
  input  logic [$clog2(NREGS)-1:0]                 live_idx,
  output logic [DATA_W-1:0]                        live_data
);
  localparam int OFF_W = $clog2(NSETS) + $clog2(NREGS);
  localparam int DEPTH = NSETS * NREGS;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  // storage: no reset, write enable written out
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata     = rdata_q;
  // set 0 occupies the lowest NREGS entries
  assign live_data = mem[OFF_W'(live_idx)];
endmodule

// File: rtl/sreg_power.sv
module sreg_power
  import sreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake,
  output logic [PWR_W-1:0]  pwr,
  output logic              halting,
  output logic              halt_req
);
  logic [PWR_W-1:0] pwr_q, pwr_d;
  logic             halt_q, halt_d;

  assign halting = we && (wdata[DOZE_BIT] || wdata[SLEEP_BIT]);

  always_comb begin
    pwr_d  = pwr_q;
    halt_d = halt_q;
    if (we) begin
      pwr_d = wdata[PWR_W-1:0];
    end else if (wake) begin
      pwr_d[DOZE_BIT]  = 1'b0;
      pwr_d[SLEEP_BIT] = 1'b0;
    end
    if (halting)   halt_d = 1'b1;
    else if (wake) halt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      halt_q <= halt_d;
    end
  end

  assign pwr      = pwr_q;
  assign halt_req = halt_q;

  // R7
  halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wdata[DOZE_BIT] || wdata[SLEEP_BIT])) |=> halt_req);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !wake) |=> halt_req);
  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !we) |=> (!halt_req && !pwr[DOZE_BIT] && !pwr[SLEEP_BIT]));
endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSETS  = 16,
  parameter int NREGS  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_we,
  input  logic                     req_re,
  input  logic [DATA_W-1:0]        cur_pc,
  input  logic                     wake,
  input  logic [$clog2(NREGS)-1:0] gpr_raddr,
  output logic [DATA_W-1:0]        gpr_rdata,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     halt_req,
  output logic [DATA_W-1:0]        next_pc
);
  localparam int OFF_W = $clog2(NSETS) + $clog2(NREGS);
  localparam logic [DATA_W-1:0] CFG_WORD =
    (DATA_W'(1) << CFG_VB_BIT) | DATA_W'((NSETS - 1) & 15);
  localparam logic [ADDR_W-1:0] A_NCORE = ADDR_W'(NUM_NCORE);

  sreg_region_e      region;
  logic [OFF_W-1:0]  shd_idx;
  logic [DATA_W-1:0] shd_rdata;
  logic [PWR_W-1:0]  pwr;
  logic              halting;

  logic [DATA_W-1:0] vbase_q, vbase_d;
  logic [DATA_W-1:0] misc_q, misc_d;
  logic              sel_shd_q, sel_shd_d;

  sreg_decode #(.ADDR_W(ADDR_W), .NSETS(NSETS), .NREGS(NREGS)) u_dec (
    .addr    (req_addr),
    .region  (region),
    .shd_idx (shd_idx)
  );

  sreg_shadow_bank #(.DATA_W(DATA_W), .NSETS(NSETS), .NREGS(NREGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (req_we && region == RG_SHD),
    .re        (req_re && region == RG_SHD),
    .idx       (shd_idx),
    .wdata     (req_wdata),
    .rdata     (shd_rdata),
    .live_idx  (gpr_raddr),
    .live_data (gpr_rdata)
  );

  sreg_power #(.DATA_W(DATA_W)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (req_we && region == RG_PWR),
    .wdata    (req_wdata),
    .wake     (wake),
    .pwr      (pwr),
    .halting  (halting),
    .halt_req (halt_req)
  );

  always_comb begin
    vbase_d   = vbase_q;
    misc_d    = misc_q;
    sel_shd_d = sel_shd_q;
    if (req_we && region == RG_VBASE) vbase_d = req_wdata;
    if (req_re) begin
      sel_shd_d = (region == RG_SHD);
      case (region)
        RG_VBASE: misc_d = vbase_q;
        RG_CFG:   misc_d = CFG_WORD;
        RG_NCORE: misc_d = DATA_W'(1);
        RG_PWR:   misc_d = DATA_W'(pwr);
        default:  misc_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbase_q   <= '0;
      misc_q    <= '0;
      sel_shd_q <= 1'b0;
    end else begin
      vbase_q   <= vbase_d;
      misc_q    <= misc_d;
      sel_shd_q <= sel_shd_d;
    end
  end

  assign rd_data = sel_shd_q ? shd_rdata : misc_q;
  assign next_pc = halting ? cur_pc + DATA_W'(4) : cur_pc;

  // R2
  ncore_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_re && req_addr == A_NCORE) |=> (rd_data == DATA_W'(1)));
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_re && region == RG_NONE) |=> (rd_data == '0));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_re && !(req_we && region == RG_SHD)) |=> $stable(rd_data));
endmodule

// File: tb/sim_sreg_unit.sv
`timescale 1ns/1ps
module sim_sreg_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_we, req_re;
  logic [31:0] cur_pc;
  logic        wake;
  logic [4:0]  gpr_raddr;
  logic [31:0] gpr_rdata, rd_data, next_pc;
  logic        halt_req;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_vb;
  logic [7:0]  m_pwr;
  logic [31:0] m_shd [512];
  logic [31:0] last_rd;

  localparam logic [15:0] A_CFG = 16'h0002, A_VB = 16'h000B, A_CID = 16'h0080,
                          A_NC = 16'h0081, A_PWR = 16'h4000, A_WIN = 16'h0400;

  always #2.5 clk = ~clk;

  sreg_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_we(req_we), .req_re(req_re), .cur_pc(cur_pc), .wake(wake),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata), .rd_data(rd_data),
    .halt_req(halt_req), .next_pc(next_pc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_val(input logic [15:0] a);
    if (a == A_CFG) return 32'h0000100F;
    if (a == A_VB)  return m_vb;
    if (a == A_CID) return 32'd0;
    if (a == A_NC)  return 32'd1;
    if (a == A_PWR) return {24'd0, m_pwr};
    if (a >= A_WIN && a < A_WIN + 16'd512) return m_shd[a - A_WIN];
    return 32'd0;
  endfunction

  function automatic void model_wr(input logic [15:0] a, input logic [31:0] d);
    if (a == A_VB) m_vb = d;
    else if (a == A_PWR) m_pwr = d[7:0];
    else if (a >= A_WIN && a < A_WIN + 16'd512) m_shd[a - A_WIN] = d;
  endfunction

  // monitor: pops one expectation per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (req_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected read", rd_data, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_rd = e;
          chk(rd_data === e, t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] epc;
    @(negedge clk);
    req_addr = a; req_wdata = d; req_we = 1'b1; req_re = 1'b0;
    cur_pc = cur_pc + 32'h10;
    #1;
    epc = (a == A_PWR && (d[4] || d[5])) ? cur_pc + 32'd4 : cur_pc;
    chk(next_pc === epc, "R7 next_pc", next_pc, epc);
    model_wr(a, d);
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    req_addr = a; req_re = 1'b1; req_we = 1'b0;
    exp_q.push_back(model_val(a));
    tag_q.push_back(tag);
    @(negedge clk);
    req_re = 1'b0;
  endtask

  task automatic rdwr(input logic [15:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_re = 1'b1; req_we = 1'b1;
    exp_q.push_back(model_val(a));
    tag_q.push_back(tag);
    model_wr(a, d);
    @(negedge clk);
    req_re = 1'b0; req_we = 1'b0;
  endtask

  task automatic do_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    m_pwr[4] = 1'b0; m_pwr[5] = 1'b0;
    chk(halt_req === 1'b0, "R8 wake clears halt", {31'd0, halt_req}, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_addr = '0; req_wdata = '0; req_we = 0; req_re = 0;
    cur_pc = 32'h0000_1000; wake = 0; gpr_raddr = '0;
    m_vb = '0; m_pwr = '0; last_rd = '0;
    for (int i = 0; i < 512; i++) m_shd[i] = 32'h0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halt_req === 1'b0, "R8 reset halt", {31'd0, halt_req}, 32'd0);
    chk(rd_data === 32'd0, "R10 reset rd_data", rd_data, 32'd0);
    chk(next_pc === cur_pc, "R7 idle next_pc", next_pc, cur_pc);

    // preload every shadow entry so model and design agree
    for (int k = 0; k < 512; k++) wr(A_WIN + 16'(k), 32'hA500_0000 + 32'(k));

    rd(A_VB, "R1 vbase reset");
    rd(A_PWR, "R6 power reset");
    rd(A_CID, "R2 core index");
    rd(A_NC, "R2 core count");
    rd(A_CFG, "R3 config word");

    wr(A_VB, 32'hDEAD_BEEF); rd(A_VB, "R1 vbase rw 1");
    wr(A_VB, 32'h1234_5678); rd(A_VB, "R1 vbase rw 2");

    wr(A_WIN + 16'd0,   32'h1111_0000);
    wr(A_WIN + 16'd31,  32'h2222_001F);
    wr(A_WIN + 16'd32,  32'h3333_0020);
    wr(A_WIN + 16'd37,  32'h4444_0025);
    wr(A_WIN + 16'd511, 32'h5555_01FF);
    rd(A_WIN + 16'd0,   "R4 set0 reg0");
    rd(A_WIN + 16'd31,  "R4 set0 reg31");
    rd(A_WIN + 16'd32,  "R4 set1 reg0");
    rd(A_WIN + 16'd37,  "R4 set1 reg5");
    rd(A_WIN + 16'd511, "R4 set15 reg31");

    @(negedge clk);
    gpr_raddr = 5'd0;  #1;
    chk(gpr_rdata === m_shd[0], "R5 live reg0", gpr_rdata, m_shd[0]);
    gpr_raddr = 5'd31; #1;
    chk(gpr_rdata === m_shd[31], "R5 live reg31", gpr_rdata, m_shd[31]);
    gpr_raddr = 5'd5;  #1;
    chk(gpr_rdata === m_shd[5], "R5 live reg5 not set1", gpr_rdata, m_shd[5]);

    // unmapped writes must not land anywhere
    wr(16'h0600, 32'hBAD0_0001);
    wr(16'h000C, 32'hBAD0_0002);
    wr(16'h4001, 32'hBAD0_0003);
    rd(16'h0600, "R9 read past window");
    rd(16'h4001, "R9 read unmapped");
    rd(A_WIN + 16'd0, "R9 window entry 0 untouched");
    rd(A_VB, "R9 vbase untouched");
    rd(A_PWR, "R9 power untouched");

    // non-halting power writes
    wr(A_PWR, 32'hABCD_00CF);
    rd(A_PWR, "R6 power low byte only");
    @(negedge clk);
    chk(halt_req === 1'b0, "R7 no halt without doze/sleep", {31'd0, halt_req}, 32'd0);

    // doze
    wr(A_PWR, 32'h0000_0010);
    chk(halt_req === 1'b1, "R7 doze halts", {31'd0, halt_req}, 32'd1);
    idle(4);
    chk(halt_req === 1'b1, "R8 halt held", {31'd0, halt_req}, 32'd1);
    do_wake();
    rd(A_PWR, "R8 wake clears doze bit");

    // sleep
    wr(A_PWR, 32'h0000_0021);
    chk(halt_req === 1'b1, "R7 sleep halts", {31'd0, halt_req}, 32'd1);
    rd(A_PWR, "R6 power while halted");
    do_wake();
    rd(A_PWR, "R8 wake clears sleep bit");

    // halting write together with wake: write wins
    wr(A_PWR, 32'h0000_0010);
    @(negedge clk);
    wake = 1'b1; req_we = 1'b1; req_addr = A_PWR; req_wdata = 32'h0000_0030;
    m_pwr = 8'h30;
    @(negedge clk);
    wake = 1'b0; req_we = 1'b0;
    chk(halt_req === 1'b1, "R8 write beats wake", {31'd0, halt_req}, 32'd1);
    rd(A_PWR, "R8 write beats wake value");
    do_wake();

    // read during write returns prior value; then hold
    rdwr(A_VB, 32'hCAFE_F00D, "R10 read-during-write vbase");
    rd(A_VB, "R10 vbase after write");
    rdwr(A_WIN + 16'd37, 32'h7777_7777, "R10 read-during-write shadow");
    rd(A_WIN + 16'd37, "R10 shadow after write");
    idle(3);
    chk(rd_data === last_rd, "R10 rd_data held", rd_data, last_rd);

    idle(2);
    chk(exp_q.size() == 0, "R10 pending reads", 32'(exp_q.size()), 32'd0);
    summary();
  end
endmodule